// File: doc/BRIEF.md
# Cascaded BCD Stopwatch Timebase

This block keeps stopwatch time as four BCD digits: tens of seconds, units of seconds, tenths and hundredths. It counts from 00.00 up to 59.99 and then starts again at 00.00. A free-running divider turns the system clock into one single-cycle tick per `DIVIDE` clocks. With the default ratio and a 100 MHz clock, that is one tick every 10 ms. Each tick advances the count by one hundredth, unless the hold input is high.

The digits form a mixed-radix chain of mod-10, mod-10, mod-10 and mod-6 counters. Each digit steps only on a cycle where the tick is present and every lower digit is at its terminal value. The clock frequency is never changed; the tick acts as an enable. Setting `DIVIDE` to 1 gives a tick on every clock, which is useful in simulation.

Top module: `stopwatch_timebase`

## Requirements
- R1: While `rstN` is low, all four digits and the tick divider are cleared at once, without waiting for a clock edge.
- R2: The hundredths digit goes up by one on each advance, where an advance is a tick with `holdCount` low. It counts 0 to 9.
- R3: When the hundredths digit reads 9 on an advance, it returns to 0 and the tenths digit goes up by one.
- R4: The units-of-seconds digit changes only on an advance where both the hundredths and tenths digits read 9.
- R5: The tens-of-seconds digit counts 0 to 5. It steps only on an advance where the three lower digits all read 9.
- R6: While `holdCount` is high, no digit changes. The tick divider keeps running.
- R7: On the first advance after the count reads 59.99, all four digits return to 0. No overflow indication exists.
- R8: After reset, the divider counts 0 to `DIVIDE`-1. The tick is present on the cycle where the divider count is `DIVIDE`-1, so the first advance lands on the `DIVIDE`-th rising edge after reset release.
- R9: Each digit output is 4-bit binary-coded decimal. It never shows a value above its own maximum: 9 for the three lower digits, 5 for the top digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| holdCount | input | 1 | Freezes the displayed time while high |
| centiDigit | output | 4 | Hundredths of a second, BCD |
| deciDigit | output | 4 | Tenths of a second, BCD |
| secOnesDigit | output | 4 | Units of seconds, BCD |
| secTensDigit | output | 4 | Tens of seconds, BCD, 0 to 5 |

## Verification
The bench walks through every carry boundary: x9, x99, x9.99, and the full wrap from 59.99 to 00.00. A chain that carried one cycle late, or that gated a digit only on its nearest neighbour, would show a wrong digit right after one of these boundaries. Random hold patterns, plus a long hold parked on 59.99, would expose a design in which hold failed to freeze the upper digits or stopped the divider and shifted later ticks. A reset pulse applied between clock edges would expose a reset that waits for the clock.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int NUM_DIGITS = 4;
  localparam int DIGIT_W = 4;

  typedef struct packed {
    logic advance;
    logic frozen;
  } swStrobe_t;

  function automatic int digitModulus(input int idx);
    return (idx == NUM_DIGITS - 1) ? 6 : 10;
  endfunction
endpackage

// File: rtl/sw_control.sv
module sw_control
  import sw_pkg::*;
#(
  parameter int DIVIDE = 1000000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      holdCount,
  output swStrobe_t strobe
);
  localparam int CNT_W = (DIVIDE > 1) ? $clog2(DIVIDE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIVIDE - 1);

  logic [CNT_W-1:0] divCount;
  logic tick;

  assign tick = (divCount == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCount <= '0;
    else if (tick) divCount <= '0;
    else divCount <= divCount + CNT_W'(1);
  end

  always_comb begin
    strobe.advance = tick & ~holdCount;
    strobe.frozen  = holdCount;
  end

  // R8: divider stays inside its range
  a_r8_div_range: assert property (@(posedge clk) disable iff (!rstN)
    divCount <= LAST);

  // R8: divider restarts after each tick
  a_r8_div_restart: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> divCount == '0);

  generate
    if (DIVIDE > 1) begin : g_spaced
      // R8: ticks are single-cycle pulses
      a_r8_tick_single: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/sw_digit.sv
module sw_digit #(
  parameter int MODULUS = 10,
  parameter int WIDTH   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  output logic [WIDTH-1:0] q,
  output logic             atMax
);
  localparam logic [WIDTH-1:0] MAXV = WIDTH'(MODULUS - 1);

  assign atMax = (q == MAXV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else if (en) q <= atMax ? '0 : q + WIDTH'(1);
  end

  // R9: never above the digit maximum
  a_r9_in_range: assert property (@(posedge clk) disable iff (!rstN)
    q <= MAXV);

  // R2: an enabled digit below its maximum steps by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (en && q != MAXV) |=> q == $past(q) + WIDTH'(1));

  // R3: an enabled digit at its maximum wraps to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (en && q == MAXV) |=> q == '0);

  // R6: a disabled digit keeps its value
  a_r6_steady: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(q));
endmodule

// File: rtl/sw_digit_chain.sv
module sw_digit_chain
  import sw_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  swStrobe_t                            strobe,
  output logic [NUM_DIGITS-1:0][DIGIT_W-1:0]   digits
);
  logic [NUM_DIGITS:0]   enChain;
  logic [NUM_DIGITS-1:0] atMax;

  assign enChain[0] = strobe.advance;

  generate
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
      sw_digit #(
        .MODULUS(digitModulus(i)),
        .WIDTH  (DIGIT_W)
      ) u_digit (
        .clk  (clk),
        .rstN (rstN),
        .en   (enChain[i]),
        .q    (digits[i]),
        .atMax(atMax[i])
      );
      assign enChain[i+1] = enChain[i] & atMax[i];
    end
  endgenerate

  // R6: holding freezes the whole time value
  a_r6_hold_freeze: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frozen |=> $stable(digits));

  // R4: seconds units moves only after two lower nines on an advance
  a_r4_units_gate: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.advance && digits[0] == 4'd9 && digits[1] == 4'd9)
      |=> $stable(digits[2]));

  // R5: tens digit moves only after three lower nines on an advance
  a_r5_tens_gate: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.advance && digits[0] == 4'd9 && digits[1] == 4'd9 && digits[2] == 4'd9)
      |=> $stable(digits[3]));

  // R7: full wrap from 59.99
  a_r7_rollover: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && digits[3] == 4'd5 && digits[2] == 4'd9 &&
     digits[1] == 4'd9 && digits[0] == 4'd9) |=> digits == '0);
endmodule

// File: rtl/stopwatch_timebase.sv
module stopwatch_timebase
  import sw_pkg::*;
#(
  parameter int DIVIDE = 1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdCount,
  output logic [3:0] centiDigit,
  output logic [3:0] deciDigit,
  output logic [3:0] secOnesDigit,
  output logic [3:0] secTensDigit
);
  swStrobe_t strobe;
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digits;

  sw_control #(.DIVIDE(DIVIDE)) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .holdCount(holdCount),
    .strobe   (strobe)
  );

  sw_digit_chain u_chain (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .digits(digits)
  );

  assign centiDigit   = digits[0];
  assign deciDigit    = digits[1];
  assign secOnesDigit = digits[2];
  assign secTensDigit = digits[3];
endmodule

// File: tb/stopwatch_timebase_test.sv
module stopwatch_timebase_test;
  localparam int DIV = 3;
  localparam int ITER = 36000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdCount = 1'b0;
  logic [3:0] centiDigit, deciDigit, secOnesDigit, secTensDigit;

  int tests = 0;
  int fails = 0;
  int modelV = 0;
  int modelDiv = 0;
  int holdBurst = 0;
  bit parked = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  stopwatch_timebase #(.DIVIDE(DIV)) uut (
    .clk(clk), .rstN(rstN), .holdCount(holdCount),
    .centiDigit(centiDigit), .deciDigit(deciDigit),
    .secOnesDigit(secOnesDigit), .secTensDigit(secTensDigit)
  );

  function automatic int expDigits(input int v);
    return ((v / 1000) << 12) | (((v / 100) % 10) << 8) | (((v / 10) % 10) << 4) | (v % 10);
  endfunction

  function automatic string classify(input int prev, input bit adv, input bit hold);
    if (!adv) return hold ? "R6" : "R8";
    if (prev == 5999) return "R7";
    if (prev % 1000 == 999) return "R5";
    if (prev % 100 == 99) return "R4";
    if (prev % 10 == 9) return "R3";
    return "R2";
  endfunction

  task automatic checkNow(input string t, input int v);
    int act;
    act = {16'd0, secTensDigit, secOnesDigit, deciDigit, centiDigit};
    tests++;
    if (act !== expDigits(v)) begin
      fails++;
      $display("FAIL %s: digits=%h expected=%h", t, act[15:0], expDigits(v));
    end
  endtask

  initial begin
    int guard = 0;
    while (guard < 150000) begin
      @(posedge clk);
      guard++;
    end
    fails++;
    $display("FAIL watchdog: cycles=%0d expected<150000", guard);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #5;
    checkNow("R1", 0);  // reset state
    @(negedge clk);
    rstN = 1'b1;
    tag = "R8";
    for (int i = 0; i < ITER; i++) begin
      checkNow(tag, modelV);
      if (i == 9000) begin
        // R1: asynchronous clear between edges
        #5 rstN = 1'b0;
        #1 checkNow("R1", 0);
        holdCount = 1'b0;
        modelV = 0;
        modelDiv = 0;
        @(negedge clk);
        rstN = 1'b1;
        tag = "R8";
        continue;
      end
      // choose hold: directed park on 59.99, else random
      if (modelV == 5999 && !parked) begin
        parked = 1'b1;
        holdBurst = 25;
      end
      if (holdBurst > 0) begin
        holdCount = 1'b1;
        holdBurst--;
      end else begin
        holdCount = (($urandom % 5) == 0);
      end
      begin
        bit tick;
        bit adv;
        int prev;
        tick = (modelDiv == DIV - 1);
        adv = tick && !holdCount;
        prev = modelV;
        modelDiv = tick ? 0 : modelDiv + 1;
        if (adv) modelV = (modelV + 1) % 6000;
        tag = classify(prev, adv, holdCount);
      end
      @(negedge clk);
    end
    if (!parked) begin
      fails++;
      $display("FAIL R7: reached59.99=0 expected=1");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule